// File: doc/BRIEF.md
# Cache Maintenance Broadcast Filter

This block sits between the cores of a coherent cluster and decides whether a line-based cache maintenance operation is carried out only by the core that issued it, or is also forwarded to the other cores. The issuing core presents an operation code, a virtual line address, the index of the issuing core and a flag that says whether the address lies in the shareable domain. A stub translation stage turns the virtual address into a line-aligned physical address, and only that physical address is sent to the other cores.

Each core has two control bits, a coherency-participation bit and a forwarding-enable bit. An issuing core may forward only when both of its bits are set. A receiving core takes forwarded operations whenever its participation bit is set, whatever its forwarding-enable bit holds. A forwarded operation is offered at the same time to every eligible receiver through a per-core valid line. The issuing core's operation completes only after every one of those receivers has acknowledged. Only one broadcast is in flight at a time, and the request port stalls while it is outstanding.

Top module: `cmb_filter`

## Requirements
- R1: After reset, `req_ready` is 1, `bc_valid` is all zero and `done` is 0.
- R2: An accepted request with `req_shared` = 0 is never forwarded. `done` is 1 with `done_fwd` = 0 in the cycle after acceptance.
- R3: A request is forwarded only if the issuer's `smp_en` bit and `fw_en` bit are both 1. Otherwise it completes locally, like R2.
- R4: A forwarded operation is offered to every core other than the issuer whose `smp_en` bit is 1, whatever its `fw_en` bit holds. It is never offered to the issuer.
- R5: `bc_pa` equals (`req_va` + XLAT_OFS) modulo 2^AW with the low LINE_BITS bits cleared. `bc_op` equals the request's code. Both stay stable while a broadcast is in flight.
- R6: Each `bc_valid[i]` stays high until `bc_ack[i]` is sampled high and drops in the next cycle. Acknowledgements on lines that are not pending have no effect. `done` with `done_fwd` = 1 is raised exactly one cycle after the last pending acknowledgement.
- R7: While a broadcast is in flight, `req_ready` is 0 and requests are ignored. No new broadcast appears and no extra `done` appears.
- R8: Operation codes are 1 = clean, 2 = invalidate, 3 = clean plus invalidate. Code 0 is a no-op: it completes locally and is never forwarded.
- R9: A request that qualifies for forwarding but finds no eligible receiver completes in the next cycle with `done_fwd` = 0.
- R10: The receiver set is fixed when the request is accepted. Changes to `smp_en` or `fw_en` during a broadcast do not change which `bc_valid` lines are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | NCORE | Per-core coherency participation bit |
| fw_en | input | NCORE | Per-core forwarding-enable bit |
| req_valid | input | 1 | Maintenance request present |
| req_ready | output | 1 | Request port can accept |
| req_src | input | SRC_W | Index of the issuing core |
| req_op | input | 2 | Operation code (R8) |
| req_va | input | AW | Virtual line address from the issuer |
| req_shared | input | 1 | Address lies in the shareable domain |
| bc_valid | output | NCORE | Forwarded operation pending at each receiver |
| bc_op | output | 2 | Forwarded operation code |
| bc_pa | output | AW | Forwarded physical line address |
| bc_ack | input | NCORE | Per-receiver completion acknowledgement |
| done | output | 1 | One-cycle completion pulse for the issuer |
| done_fwd | output | 1 | Qualifies `done`: the operation was forwarded |

## Verification
The bench builds the block with four cores, 32-bit addresses, 32-byte lines and a translation offset of 0x1000_0000. Four cores give every issuer index at least two possible receivers, so issuer exclusion, mixed participation and forwarding-enable patterns, and partial acknowledgement orders can all be exercised. The offset lets one address near the top of the space show the modulo wrap of R5. Acknowledgements come from a pseudo-random pattern that also hits non-pending lines, and the pattern can be suspended to hold a broadcast open while requests and control-bit changes arrive.

// File: rtl/cmb_pkg.sv
package cmb_pkg;
  typedef enum logic [1:0] {
    CMO_NOP       = 2'd0,
    CMO_CLEAN     = 2'd1,
    CMO_INV       = 2'd2,
    CMO_CLEAN_INV = 2'd3
  } cmo_op_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_BCAST = 1'b1
  } bst_e;
endpackage

// File: rtl/cmb_xlate_stub.sv
module cmb_xlate_stub #(
  parameter int          AW        = 32,
  parameter int          LINE_BITS = 5,
  parameter logic [AW-1:0] XLAT_OFS = '0
) (
  input  logic [AW-1:0] va,
  output logic [AW-1:0] pa
);
  logic [AW-1:0] sum;

  always_comb begin
    sum = va + XLAT_OFS;
    pa  = {sum[AW-1:LINE_BITS], {LINE_BITS{1'b0}}};
  end
endmodule

// File: rtl/cmb_route.sv
module cmb_route
  import cmb_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int SRC_W = 2
) (
  input  logic [NCORE-1:0] smp_en,
  input  logic [NCORE-1:0] fw_en,
  input  logic [SRC_W-1:0] src,
  input  logic             shared,
  input  logic [1:0]       op,
  output logic             send_ok,
  output logic [NCORE-1:0] rcv_mask
);
  logic [NCORE-1:0] is_src;

  for (genvar i = 0; i < NCORE; i++) begin : g_rcv
    localparam logic [SRC_W-1:0] IDX = SRC_W'(i);
    assign is_src[i]   = (src == IDX);
    assign rcv_mask[i] = smp_en[i] & ~is_src[i];
  end

  logic src_smp, src_fw;
  assign src_smp = |(smp_en & is_src);
  assign src_fw  = |(fw_en & is_src);

  assign send_ok = shared & src_smp & src_fw & (op != CMO_NOP);
endmodule

// File: rtl/cmb_track.sv
module cmb_track
  import cmb_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int AW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             go,
  input  logic [NCORE-1:0] mask,
  input  logic [1:0]       op,
  input  logic [AW-1:0]    pa,
  input  logic [NCORE-1:0] ack,
  output logic             idle,
  output logic [NCORE-1:0] pend,
  output logic [1:0]       op_out,
  output logic [AW-1:0]    pa_out,
  output logic             done,
  output logic             done_fwd
);
  bst_e             st_q, st_d;
  logic [NCORE-1:0] pend_q, pend_d;
  logic [1:0]       op_q;
  logic [AW-1:0]    pa_q;
  logic             done_q, done_d, fwd_q, fwd_d;
  logic             cap_en;

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    done_d = 1'b0;
    fwd_d  = 1'b0;
    cap_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          if (go && (mask != '0)) begin
            st_d   = ST_BCAST;
            pend_d = mask;
            cap_en = 1'b1;
          end else begin
            done_d = 1'b1;
          end
        end
      end
      ST_BCAST: begin
        pend_d = pend_q & ~ack;
        if (pend_d == '0) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          fwd_d  = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= '0;
      done_q <= 1'b0;
      fwd_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      done_q <= done_d;
      fwd_q  <= fwd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= '0;
      pa_q <= '0;
    end else if (cap_en) begin
      op_q <= op;
      pa_q <= pa;
    end
  end

  assign idle     = (st_q == ST_IDLE);
  assign pend     = pend_q;
  assign op_out   = op_q;
  assign pa_out   = pa_q;
  assign done     = done_q;
  assign done_fwd = fwd_q;
endmodule

// File: rtl/cmb_filter.sv
module cmb_filter
  import cmb_pkg::*;
#(
  parameter int            NCORE     = 4,
  parameter int            AW        = 32,
  parameter int            LINE_BITS = 5,
  parameter logic [AW-1:0] XLAT_OFS  = 32'h1000_0000,
  localparam int           SRC_W     = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCORE-1:0] smp_en,
  input  logic [NCORE-1:0] fw_en,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SRC_W-1:0] req_src,
  input  logic [1:0]       req_op,
  input  logic [AW-1:0]    req_va,
  input  logic             req_shared,
  output logic [NCORE-1:0] bc_valid,
  output logic [1:0]       bc_op,
  output logic [AW-1:0]    bc_pa,
  input  logic [NCORE-1:0] bc_ack,
  output logic             done,
  output logic             done_fwd
);
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic [AW-1:0]    pa;
  logic             send_ok;
  logic [NCORE-1:0] rcv_mask;
  logic             idle;

  cmb_xlate_stub #(.AW(AW), .LINE_BITS(LINE_BITS), .XLAT_OFS(XLAT_OFS)) u_xlate (
    .va (req_va),
    .pa (pa)
  );

  cmb_route #(.NCORE(NCORE), .SRC_W(SRC_W)) u_route (
    .smp_en   (smp_en),
    .fw_en    (fw_en),
    .src      (req_src),
    .shared   (req_shared),
    .op       (req_op),
    .send_ok  (send_ok),
    .rcv_mask (rcv_mask)
  );

  cmb_track #(.NCORE(NCORE), .AW(AW)) u_track (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .accept   (req_valid & idle),
    .go       (send_ok),
    .mask     (rcv_mask),
    .op       (req_op),
    .pa       (pa),
    .ack      (bc_ack),
    .idle     (idle),
    .pend     (bc_valid),
    .op_out   (bc_op),
    .pa_out   (bc_pa),
    .done     (done),
    .done_fwd (done_fwd)
  );

  assign req_ready = idle;
endmodule

// File: rtl/cmb_filter_chk.sv
module cmb_filter_chk #(
  parameter int NCORE     = 4,
  parameter int AW        = 32,
  parameter int LINE_BITS = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_shared,
  input logic [1:0]       req_op,
  input logic [NCORE-1:0] bc_valid,
  input logic [NCORE-1:0] bc_ack,
  input logic [1:0]       bc_op,
  input logic [AW-1:0]    bc_pa,
  input logic             done,
  input logic             done_fwd
);
  a_r7_stall_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid != '0) |-> !req_ready);

  a_r2_local_only: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_shared) |=> (done && !done_fwd && bc_valid == '0));

  a_r8_nop_local: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'd0) |=> (done && !done_fwd));

  a_r6_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ((bc_valid & bc_ack) != '0) |=> ((bc_valid & $past(bc_valid & bc_ack)) == '0));

  a_r6_done_after_bcast: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_fwd) |-> ($past(bc_valid) != '0 && bc_valid == '0));

  a_r10_mask_only_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid != '0 && $past(bc_valid) != '0) |-> ((bc_valid & ~$past(bc_valid)) == '0));

  a_r5_payload_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid != '0 && $past(bc_valid) != '0) |-> ($stable(bc_pa) && $stable(bc_op)));

  a_r5_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid != '0) |-> (bc_pa[LINE_BITS-1:0] == '0 && bc_op != 2'd0));
endmodule

bind cmb_filter cmb_filter_chk #(.NCORE(NCORE), .AW(AW), .LINE_BITS(LINE_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_shared (req_shared),
  .req_op     (req_op),
  .bc_valid   (bc_valid),
  .bc_ack     (bc_ack),
  .bc_op      (bc_op),
  .bc_pa      (bc_pa),
  .done       (done),
  .done_fwd   (done_fwd)
);

// File: tb/cmb_filter_bench.sv
`timescale 1ns/1ps
module cmb_filter_bench;
  localparam int          N   = 4;
  localparam int          AW  = 32;
  localparam int          LB  = 5;
  localparam logic [31:0] OFS = 32'h1000_0000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] smp_en = '1, fw_en = '1;
  logic         req_valid = 1'b0, req_shared = 1'b0;
  logic [1:0]   req_src = '0, req_op = '0;
  logic [AW-1:0] req_va = '0;
  logic [N-1:0] bc_ack = '0;
  logic         req_ready, done, done_fwd;
  logic [N-1:0] bc_valid;
  logic [1:0]   bc_op;
  logic [AW-1:0] bc_pa;

  always #4 clk = ~clk;

  cmb_filter #(.NCORE(N), .AW(AW), .LINE_BITS(LB), .XLAT_OFS(OFS)) u_cmb_filter (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .fw_en(fw_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
    .req_op(req_op), .req_va(req_va), .req_shared(req_shared),
    .bc_valid(bc_valid), .bc_op(bc_op), .bc_pa(bc_pa), .bc_ack(bc_ack),
    .done(done), .done_fwd(done_fwd)
  );

  int    tests = 0, fails = 0, cyc = 0;
  string tag = "R1";
  bit    ack_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  // behavioural reference model
  bit          m_busy, m_done, m_fwd;
  int unsigned m_pend, m_op;
  longint unsigned m_pa;
  int unsigned rel;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_pend = 0; m_done = 0; m_fwd = 0; m_op = 0; m_pa = 0; rel = 0;
    end else begin
      m_done = 0; m_fwd = 0;
      if (rel < 2) rel++;
      else if (m_busy) begin
        m_pend = m_pend & ~int'(bc_ack);
        if (m_pend == 0) begin m_busy = 0; m_done = 1; m_fwd = 1; end
      end else if (req_valid) begin
        int unsigned rcv;
        rcv = int'(smp_en) & ~(1 << req_src) & 32'hF;
        if (req_shared && req_op != 0 && smp_en[req_src] && fw_en[req_src] && rcv != 0) begin
          m_busy = 1; m_pend = rcv; m_op = req_op;
          m_pa = ((longint'(req_va) + longint'(OFS)) % (64'd1 << AW)) & ~((64'd1 << LB) - 1);
        end else begin
          m_done = 1;
        end
      end
    end
  end

  task automatic chk(string field, longint unsigned act, longint unsigned exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, field, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("req_ready", req_ready, !m_busy);
      chk("bc_valid", bc_valid, m_busy ? m_pend : 0);
      chk("done", done, m_done);
      if (done) chk("done_fwd", done_fwd, m_fwd);
      if (m_busy) begin
        chk("bc_pa", bc_pa, m_pa);
        chk("bc_op", bc_op, m_op);
      end
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    bc_ack = ack_en ? lfsr[N-1:0] : '0;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] src, input logic [1:0] op,
                       input logic [AW-1:0] va, input logic sh);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_src = src; req_op = op; req_va = va; req_shared = sh; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1"; // reset state compared each cycle
    repeat (4) @(negedge clk);
    chk("reset bc_valid", bc_valid, 0);
    ack_en = 1'b1;

    tag = "R2"; issue(2'd0, 2'd1, 32'h0000_4000, 1'b0);
    issue(2'd3, 2'd3, 32'h0000_8040, 1'b0);

    tag = "R3"; fw_en = 4'b1110; issue(2'd0, 2'd2, 32'h0000_1000, 1'b1);
    fw_en = 4'b1111; smp_en = 4'b1101; issue(2'd1, 2'd1, 32'h0000_2000, 1'b1);

    tag = "R4"; smp_en = 4'b1011; fw_en = 4'b0011; issue(2'd0, 2'd3, 32'h0000_3000, 1'b1);
    smp_en = 4'b1111; fw_en = 4'b0100; issue(2'd2, 2'd1, 32'h0000_3100, 1'b1);

    tag = "R5"; fw_en = 4'b1111; issue(2'd3, 2'd2, 32'hF000_123F, 1'b1);
    issue(2'd1, 2'd3, 32'h0ABC_DEF7, 1'b1);

    tag = "R8"; issue(2'd0, 2'd0, 32'h0000_5000, 1'b1);

    tag = "R9"; smp_en = 4'b0001; fw_en = 4'b0001; issue(2'd0, 2'd1, 32'h0000_6000, 1'b1);

    tag = "R6"; smp_en = 4'b1111; fw_en = 4'b1111; ack_en = 1'b0;
    @(negedge clk);
    req_src = 2'd2; req_op = 2'd1; req_va = 32'h0000_7000; req_shared = 1'b1; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    repeat (5) @(negedge clk);
    tag = "R7";
    req_src = 2'd0; req_op = 2'd2; req_va = 32'h0000_9000; req_valid = 1'b1;
    repeat (4) @(negedge clk);
    req_valid = 1'b0;
    tag = "R10"; smp_en = 4'b0000; fw_en = 4'b0000;
    repeat (3) @(negedge clk);
    tag = "R6"; ack_en = 1'b1; smp_en = 4'b1111; fw_en = 4'b1111;
    wait_idle();

    for (int k = 0; k < 40; k++) begin
      tag = (k % 2) ? "R4" : "R6";
      smp_en = 4'(k * 7 + 3); fw_en = 4'(k * 5 + 9);
      issue(2'(k), 2'(k % 3 + 1), 32'(k * 32'h0101_0033), 1'b1);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule